// File: doc/BRIEF.md
# Two-Threshold Lockable Watchdog Counter

This block is an up-counting watchdog for the always-on domain. A counter starts from zero after reset and advances by one on each clock while it is enabled and its gates are open. Two thresholds act on it. Crossing the lower one raises a sticky "early warning" interrupt, and optionally a wakeup request, which software must acknowledge. Crossing the higher one raises a reset request, which stays up until the block is reset. Software keeps the system alive by writing zero into the count, which is called petting.

Control uses a simple register-style port: a write strobe with address and data, and a combinational read port. The address map is 0 control, 1 count, 2 warning threshold, 3 reset threshold, 4 lock and 5 status/acknowledge. Setting the lock freezes the control and both thresholds until the next reset. The count stays writable, so petting keeps working. Two inputs gate counting. A sleep input stops the count when the pause-in-sleep bit is set. An external run input stops the count unconditionally, for example during debug.

Top module: `bark_bite_wdog`

## Requirements
- R1: After reset the count reads 0, all three outputs are low, the lock reads 0, both thresholds read all ones and the control reads 0.
- R2: Control bit 0 (address 0) enables counting. While it is set and no gate holds, the count rises by exactly one per clock. While it is clear, the count holds.
- R3: The warning interrupt rises one clock after an enabled count is greater than or equal to the warning threshold (address 2). It stays high until acknowledged or reset.
- R4: The wakeup output equals the warning interrupt when control bit 2 is set. It stays low when control bit 2 is clear.
- R5: The reset request rises one clock after an enabled count is greater than or equal to the reset threshold (address 3). It stays high until reset, and an acknowledge does not affect it.
- R6: Writing a value with bit 0 set to address 5 clears the warning interrupt, unless the warning condition holds in that same cycle. Reading address 5 returns the warning flag in bit 0 and the reset request in bit 1.
- R7: A write to address 1 loads the count with the written value on that clock. Writing zero pets the watchdog, and counting resumes from zero.
- R8: Writing a value with bit 0 set to address 4 sets the lock. While the lock is set, writes to addresses 0, 2 and 3 are ignored. No write clears the lock.
- R9: While the lock is set, count writes and acknowledges still take effect.
- R10: When control bit 1 is set and the sleep input is high, the count holds. When control bit 1 is clear, the count advances during sleep.
- R11: When the run input is low, the count holds whatever the other settings are.
- R12: The count saturates at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | CNT_W | Combinational read data |
| sleep_i | input | 1 | System is in a low-power state |
| run_i | input | 1 | External count permit; low halts the count |
| bark_irq_o | output | 1 | Sticky warning interrupt |
| bark_wake_o | output | 1 | Warning wakeup request |
| bite_rst_o | output | 1 | Reset request |

## Verification
The bench runs an 8-bit counter and sweeps the warning threshold over a range of small values, with the reset threshold a fixed distance above it. On every clock it compares the interrupt, the wakeup and the reset request against the first cycle predicted from the threshold. This tells an off-by-one compare or an extra pipeline stage apart from a correct one. The wakeup-enable bit alternates across the sweep, which separates a gated wakeup from one wired straight to the interrupt. Separate patterns then drive pet-then-acknowledge against acknowledge-while-over-threshold, blocked writes after the lock, each counting gate on its own, and a count loaded near the top, so that saturation can be told apart from wrap-around.

// File: rtl/bbw_pkg.sv
package bbw_pkg;
  typedef enum logic [2:0] {
    A_CTRL  = 3'd0,
    A_COUNT = 3'd1,
    A_BARK  = 3'd2,
    A_BITE  = 3'd3,
    A_LOCK  = 3'd4,
    A_STAT  = 3'd5
  } addr_e;

  typedef struct packed {
    logic wake_en;
    logic pause_sleep;
    logic enable;
  } ctrl_t;

  localparam int unsigned CTRL_W = 3;
endpackage

// File: rtl/bbw_regs.sv
module bbw_regs
  import bbw_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output ctrl_t            ctrl_o,
  output logic [CNT_W-1:0] bark_th_o,
  output logic [CNT_W-1:0] bite_th_o,
  output logic             lock_o,
  output logic             ack_o,
  output logic             cnt_wr_o
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] bark_q, bark_d, bite_q, bite_d;
  logic             lock_q, lock_d;
  logic             cfg_wr;

  // configuration writes pass only while unlocked
  assign cfg_wr = wr_en_i & ~lock_q;

  always_comb begin
    ctrl_d = ctrl_q;
    bark_d = bark_q;
    bite_d = bite_q;
    lock_d = lock_q;
    if (cfg_wr && wr_addr_i == A_CTRL) ctrl_d = ctrl_t'(wr_data_i[CTRL_W-1:0]);
    if (cfg_wr && wr_addr_i == A_BARK) bark_d = wr_data_i;
    if (cfg_wr && wr_addr_i == A_BITE) bite_d = wr_data_i;
    if (wr_en_i && wr_addr_i == A_LOCK && wr_data_i[0]) lock_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      bark_q <= '1;
      bite_q <= '1;
      lock_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      bark_q <= bark_d;
      bite_q <= bite_d;
      lock_q <= lock_d;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign bark_th_o = bark_q;
  assign bite_th_o = bite_q;
  assign lock_o    = lock_q;
  assign ack_o     = wr_en_i && wr_addr_i == A_STAT && wr_data_i[0];
  assign cnt_wr_o  = wr_en_i && wr_addr_i == A_COUNT;
endmodule

// File: rtl/bbw_counter.sv
module bbw_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = load_i | (adv_i & (cnt_q != CNT_MAX));

  always_comb begin
    if (load_i) cnt_d = load_val_i;
    else        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/bbw_events.sv
module bbw_events #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             armed_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] bark_th_i,
  input  logic [CNT_W-1:0] bite_th_i,
  input  logic             ack_i,
  output logic             bark_o,
  output logic             bite_o
);
  logic bark_q, bark_d, bite_q, bite_d;
  logic bark_hit, bite_hit;

  assign bark_hit = armed_i & (cnt_i >= bark_th_i);
  assign bite_hit = armed_i & (cnt_i >= bite_th_i);

  always_comb begin
    // a live warning condition wins over an acknowledge
    bark_d = bark_hit | (bark_q & ~ack_i);
    bite_d = bite_hit | bite_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bark_q <= 1'b0;
      bite_q <= 1'b0;
    end else begin
      bark_q <= bark_d;
      bite_q <= bite_d;
    end
  end

  assign bark_o = bark_q;
  assign bite_o = bite_q;
endmodule

// File: rtl/bark_bite_wdog.sv
module bark_bite_wdog
  import bbw_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             sleep_i,
  input  logic             run_i,
  output logic             bark_irq_o,
  output logic             bark_wake_o,
  output logic             bite_rst_o
);
  localparam int unsigned PAD_W = CNT_W - CTRL_W;

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] bark_th, bite_th, cnt_val;
  logic             lock_val, ack, cnt_wr, adv, bark, bite;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  bbw_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl),
    .bark_th_o (bark_th),
    .bite_th_o (bite_th),
    .lock_o    (lock_val),
    .ack_o     (ack),
    .cnt_wr_o  (cnt_wr)
  );

  assign adv = ctrl.enable & run_i & ~(ctrl.pause_sleep & sleep_i);

  bbw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .adv_i      (adv),
    .load_i     (cnt_wr),
    .load_val_i (wr_data_i),
    .cnt_o      (cnt_val)
  );

  bbw_events #(.CNT_W(CNT_W)) u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .armed_i   (ctrl.enable),
    .cnt_i     (cnt_val),
    .bark_th_i (bark_th),
    .bite_th_i (bite_th),
    .ack_i     (ack),
    .bark_o    (bark),
    .bite_o    (bite)
  );

  always_comb begin
    case (rd_addr_i)
      A_CTRL:  rd_data_o = {{PAD_W{1'b0}}, ctrl};
      A_COUNT: rd_data_o = cnt_val;
      A_BARK:  rd_data_o = bark_th;
      A_BITE:  rd_data_o = bite_th;
      A_LOCK:  rd_data_o = {{(CNT_W-1){1'b0}}, lock_val};
      A_STAT:  rd_data_o = {{(CNT_W-2){1'b0}}, bite, bark};
      default: rd_data_o = '0;
    endcase
  end

  assign bark_irq_o  = bark;
  assign bark_wake_o = bark & ctrl.wake_en;
  assign bite_rst_o  = bite;
endmodule

// File: rtl/bbw_checker.sv
module bbw_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             wr_en_i,
  input logic [2:0]       wr_addr_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic             run_i,
  input logic             bark_irq_o,
  input logic             bark_wake_o,
  input logic             bite_rst_o,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] bark_th,
  input logic             lock_val
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic cnt_write, ack_write;
  assign cnt_write = wr_en_i && wr_addr_i == 3'd1;
  assign ack_write = wr_en_i && wr_addr_i == 3'd5 && wr_data_i[0];

  assert_no_overflow_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cnt_val == CNT_MAX && !cnt_write) |=> cnt_val == CNT_MAX);

  assert_bark_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bark_irq_o && !ack_write) |=> bark_irq_o);

  assert_wake_implies_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    bark_wake_o |-> bark_irq_o);

  assert_bite_held_R5: assert property (@(posedge clk_i) disable iff (!rst_n)
    bite_rst_o |=> bite_rst_o);

  assert_lock_one_way_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    lock_val |=> lock_val);

  assert_locked_thresh_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (lock_val && wr_en_i && wr_addr_i == 3'd2) |=> $stable(bark_th));

  assert_run_low_holds_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!run_i && !cnt_write) |=> $stable(cnt_val));
endmodule

bind bark_bite_wdog bbw_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .run_i       (run_i),
  .bark_irq_o  (bark_irq_o),
  .bark_wake_o (bark_wake_o),
  .bite_rst_o  (bite_rst_o),
  .cnt_val     (cnt_val),
  .bark_th     (bark_th),
  .lock_val    (lock_val)
);

// File: tb/bark_bite_wdog_test.sv
`timescale 1ns/100ps
module bark_bite_wdog_test;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst_ni, wr_en, sleep, run;
  logic [2:0]   wr_addr, rd_addr;
  logic [W-1:0] wr_data, rd_data;
  logic         irq, wake, bite;
  int           checks = 0;
  int           failures = 0;

  always #2.5 clk = ~clk;

  bark_bite_wdog #(.CNT_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sleep_i(sleep), .run_i(run), .bark_irq_o(irq), .bark_wake_o(wake),
    .bite_rst_o(bite)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_addr = a; #0.5; v = int'(rd_data);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; sleep = 1'b0; run = 1'b1; wr_en = 1'b0;
    wait_n(2);
    rst_ni = 1'b1;
    wait_n(3);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v;
    wr_addr = 3'd0; wr_data = '0; rd_addr = 3'd0;
    @(negedge clk);
    do_reset();

    // R1 reset state
    rd(3'd1, v); chk("R1 count", v, 0);
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd2, v); chk("R1 bark thr", v, 255);
    rd(3'd3, v); chk("R1 bite thr", v, 255);
    rd(3'd4, v); chk("R1 lock", v, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 wake", int'(wake), 0);
    chk("R1 bite", int'(bite), 0);

    // R2 disabled: count holds
    wait_n(4);
    rd(3'd1, v); chk("R2 disabled hold", v, 0);

    // R2 R3 R4 R5: threshold sweep, wake enable alternating
    for (int th = 0; th < 8; th++) begin
      int we;
      we = th % 2;
      do_reset();
      wr(3'd2, th);
      wr(3'd3, th + 3);
      wr(3'd0, 1 + 4 * we);
      for (int n = 0; n < 14; n++) begin
        rd(3'd1, v); chk("R2 count step", v, n);
        chk("R3 irq timing", int'(irq), int'(n >= th + 1));
        chk("R4 wake gating", int'(wake), int'(we == 1 && n >= th + 1));
        chk("R5 bite timing", int'(bite), int'(n >= th + 4));
        @(negedge clk);
      end
    end

    // R6 R7: pet then acknowledge
    do_reset();
    wr(3'd2, 3);
    wr(3'd3, 200);
    wr(3'd0, 1);
    wait_n(6);
    chk("R3 irq up", int'(irq), 1);
    wr(3'd1, 0);
    rd(3'd1, v); chk("R7 pet loads zero", v, 0);
    chk("R3 sticky after pet", int'(irq), 1);
    wr(3'd5, 1);
    chk("R6 ack clears", int'(irq), 0);
    rd(3'd1, v); chk("R7 counts on from zero", v, 1);
    rd(3'd5, v); chk("R6 status after ack", v, 0);
    wr(3'd1, 40);
    rd(3'd1, v); chk("R7 load value", v, 40);

    // R5 R6: ack while over threshold
    do_reset();
    wr(3'd2, 2);
    wr(3'd3, 4);
    wr(3'd0, 1);
    wait_n(8);
    wr(3'd5, 1);
    chk("R6 live condition wins", int'(irq), 1);
    chk("R5 bite ignores ack", int'(bite), 1);
    rd(3'd5, v); chk("R6 status bits", v, 3);

    // R8 R9 lock
    do_reset();
    wr(3'd2, 9);
    wr(3'd3, 20);
    wr(3'd0, 1);
    wr(3'd4, 1);
    rd(3'd4, v); chk("R8 lock set", v, 1);
    wr(3'd2, 1);
    rd(3'd2, v); chk("R8 bark thr frozen", v, 9);
    wr(3'd3, 2);
    rd(3'd3, v); chk("R8 bite thr frozen", v, 20);
    wr(3'd0, 0);
    rd(3'd0, v); chk("R8 ctrl frozen", v, 1);
    wr(3'd4, 0);
    rd(3'd4, v); chk("R8 lock not cleared", v, 1);
    wr(3'd1, 0);
    rd(3'd1, v); chk("R9 pet while locked", v, 0);
    wait_n(12);
    chk("R9 irq up while locked", int'(irq), 1);
    wr(3'd1, 0);
    wr(3'd5, 1);
    chk("R9 ack while locked", int'(irq), 0);

    // R10 pause in sleep
    do_reset();
    wr(3'd0, 3);
    sleep = 1'b1;
    wait_n(5);
    rd(3'd1, v); chk("R10 paused in sleep", v, 0);
    sleep = 1'b0;
    wait_n(4);
    rd(3'd1, v); chk("R10 resumes awake", v, 4);
    wr(3'd0, 1);
    rd(3'd1, v); chk("R10 count at write", v, 5);
    sleep = 1'b1;
    wait_n(3);
    rd(3'd1, v); chk("R10 counts in sleep without pause", v, 8);

    // R11 external run gate
    run = 1'b0;
    wait_n(4);
    rd(3'd1, v); chk("R11 run low holds", v, 8);
    run = 1'b1;
    wait_n(2);
    rd(3'd1, v); chk("R11 run high counts", v, 10);

    // R12 saturation
    wr(3'd1, 253);
    rd(3'd1, v); chk("R12 loaded", v, 253);
    wait_n(6);
    rd(3'd1, v); chk("R12 saturates", v, 255);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule